// File: doc/BRIEF.md
# Locked Oscillator Control Register

This block is a single byte-wide control register placed on a simple memory-mapped byte bus. It holds the enables for three oscillators and for two clock-failure detectors. It also holds a flash power-down enable and a two-bit selector that picks the system clock source. Each of these settings is driven out on its own port, so the oscillator circuits and the clock multiplexer can use them directly.

Software cannot change the register by accident. A write only lands once a two-byte key has been written to the register's own address: first 0xE7, then 0x18. The write after that updates every field, and the register is locked again as soon as that write completes. A wrong byte at any point in the key returns the sequence to its locked idle state. Reads have no side effects and always show the current contents.

Top module: `osc_ctl_lockreg`

## Requirements
- R1: After reset the fields read as follows: internal oscillator enable (bit 7) = 1, crystal enable (bit 6) = 0, watchdog oscillator enable (bit 5) = 1, primary failure-detect enable (bit 4) = 0, watchdog failure-detect enable (bit 3) = 0, clock source select (bits 1:0) = 00.
- R2: The flash power-down bit (bit 2) resets to 1 when `rst_opt` is 0, and to 0 when `rst_opt` is 1.
- R3: Each field port always equals its bit of the stored byte: bit 7 `int_osc_en`, bit 6 `xtal_osc_en`, bit 5 `wdt_osc_en`, bit 4 `pri_fail_det_en`, bit 3 `wdt_fail_det_en`, bit 2 `flash_pd_en`, bits 1:0 `clk_src_sel`.
- R4: `rd_data` equals the stored byte, in the same cycle, whenever `rd_en` is high and `addr` is 0xF86, whether the register is locked or not. Otherwise `rd_data` is 0x00.
- R5: While the register is locked, a write to 0xF86 never changes the stored byte, even when the data is a key byte.
- R6: A write of 0xE7 to 0xF86, directly followed by a write of 0x18 to 0xF86, unlocks the register. The next write to 0xF86 stores all eight data bits, and they are visible from the following cycle.
- R7: The register locks again once one write has been stored. A second write without a new key leaves it unchanged.
- R8: A write of any value other than 0x18 directly after 0xE7 returns the sequence to locked idle. This includes a second 0xE7. A full new key is then needed.
- R9: A first key write that is not 0xE7 leaves the sequence locked and idle.
- R10: Writes to any address other than 0xF86 change neither the stored byte nor the key progress. So 0xE7, then a write elsewhere, then 0x18 still unlocks.
- R11: When a read and the storing write hit the register in the same cycle, `rd_data` shows the old byte in that cycle and the new byte in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_opt | input | 1 | Reset option; selects the flash power-down reset value |
| addr | input | 12 | Byte bus address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data |
| int_osc_en | output | 1 | Internal oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| wdt_osc_en | output | 1 | Watchdog oscillator enable |
| pri_fail_det_en | output | 1 | Primary clock failure-detect enable |
| wdt_fail_det_en | output | 1 | Watchdog clock failure-detect enable |
| flash_pd_en | output | 1 | Flash power-down enable |
| clk_src_sel | output | 2 | System clock source select |

## Verification
Two functions can fall in the same cycle: a read of the register and the write that stores a new value after a full key. A directed case raises `rd_en` and `wr_en` together on the storing write. The bench expects the old byte on `rd_data` in that cycle and the new byte one cycle later. Random traffic also mixes read and write strobes freely. In every cycle the bench model judges the read data against the byte held before that clock edge.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   typedef struct packed {
      logic       int_en;
      logic       xtal_en;
      logic       wdt_en;
      logic       pri_fd_en;
      logic       wdt_fd_en;
      logic       flash_pd;
      logic [1:0] clk_sel;
   } osc_fields_t;

   localparam int FIELDS_W = $bits(osc_fields_t);

   function automatic osc_fields_t reset_fields(input logic opt);
      osc_fields_t f;
      f.int_en    = 1'b1;
      f.xtal_en   = 1'b0;
      f.wdt_en    = 1'b1;
      f.pri_fd_en = 1'b0;
      f.wdt_fd_en = 1'b0;
      f.flash_pd  = ~opt;
      f.clk_sel   = 2'b00;
      return f;
   endfunction

endpackage

// File: rtl/osc_key_fsm.sv
module osc_key_fsm
   import osc_ctl_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter logic [7:0]  KEY_A  = 8'hE7,
   parameter logic [7:0]  KEY_B  = 8'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_wr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              commit,
   output key_state_e        state
);

   key_state_e state_nx;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("osc_key_fsm: DATA_W must be 8");
      end
      if (KEY_A == KEY_B) begin : g_bad_keys
         $error("osc_key_fsm: key bytes must differ");
      end
   endgenerate

   always_comb begin
      state_nx = state;
      if (hit_wr) begin
         unique case (state)
            KS_LOCKED: state_nx = (wr_data == KEY_A) ? KS_HALF : KS_LOCKED;
            KS_HALF:   state_nx = (wr_data == KEY_B) ? KS_OPEN : KS_LOCKED;
            KS_OPEN:   state_nx = KS_LOCKED;
            default:   state_nx = KS_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= KS_LOCKED;
      else        state <= state_nx;
   end

   assign commit = hit_wr && (state == KS_OPEN);

   // R7
   relock_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (state == KS_LOCKED));

   // R8
   bad_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wr && state == KS_HALF && wr_data != KEY_B) |=> (state == KS_LOCKED));

   // R10
   idle_bus_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_wr |=> $stable(state));

endmodule

// File: rtl/osc_field_store.sv
module osc_field_store
   import osc_ctl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_opt,
   input  logic              commit,
   input  logic [DATA_W-1:0] wr_data,
   output osc_fields_t       q
);

   generate
      if (DATA_W != FIELDS_W) begin : g_bad_width
         $error("osc_field_store: DATA_W must match the field layout");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= reset_fields(rst_opt);
      else if (commit) q <= osc_fields_t'(wr_data);
   end

   // R5
   hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(q));

   // R6
   store_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (q == $past(wr_data)));

endmodule

// File: rtl/osc_rd_path.sv
module osc_rd_path
   import osc_ctl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              rd_hit,
   input  osc_fields_t       q,
   output logic [DATA_W-1:0] rd_data
);

   assign rd_data = rd_hit ? DATA_W'(q) : '0;

endmodule

// File: rtl/osc_ctl_lockreg.sv
module osc_ctl_lockreg
   import osc_ctl_pkg::*;
#(
   parameter int          ADDR_W   = 12,
   parameter int          DATA_W   = 8,
   parameter logic [11:0] REG_ADDR = 12'hF86,
   parameter logic [7:0]  KEY_A    = 8'hE7,
   parameter logic [7:0]  KEY_B    = 8'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_opt,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              int_osc_en,
   output logic              xtal_osc_en,
   output logic              wdt_osc_en,
   output logic              pri_fail_det_en,
   output logic              wdt_fail_det_en,
   output logic              flash_pd_en,
   output logic [1:0]        clk_src_sel
);

   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("osc_ctl_lockreg: ADDR_W too narrow for REG_ADDR");
      end
   endgenerate

   logic        hit, wr_hit, rd_hit, commit;
   key_state_e  kstate;
   osc_fields_t fields;

   assign hit    = (addr == MY_ADDR);
   assign wr_hit = hit && wr_en;
   assign rd_hit = hit && rd_en;

   osc_key_fsm #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_wr (wr_hit),
      .wr_data(wr_data),
      .commit (commit),
      .state  (kstate)
   );

   osc_field_store #(.DATA_W(DATA_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .rst_opt(rst_opt),
      .commit (commit),
      .wr_data(wr_data),
      .q      (fields)
   );

   osc_rd_path #(.DATA_W(DATA_W)) u_rd (
      .rd_hit (rd_hit),
      .q      (fields),
      .rd_data(rd_data)
   );

   assign int_osc_en      = fields.int_en;
   assign xtal_osc_en     = fields.xtal_en;
   assign wdt_osc_en      = fields.wdt_en;
   assign pri_fail_det_en = fields.pri_fd_en;
   assign wdt_fail_det_en = fields.wdt_fd_en;
   assign flash_pd_en     = fields.flash_pd;
   assign clk_src_sel     = fields.clk_sel;

   // R4
   read_matches_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> (rd_data == {int_osc_en, xtal_osc_en, wdt_osc_en, pri_fail_det_en,
                              wdt_fail_det_en, flash_pd_en, clk_src_sel}));

   // R4
   read_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rd_data == '0));

   // R5
   locked_write_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && kstate != KS_OPEN) |=> $stable(rd_hit ? rd_data : DATA_W'(fields)));

   // R10
   foreign_write_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> ($stable(clk_src_sel) && $stable(flash_pd_en) && $stable(int_osc_en)));

endmodule

// File: tb/sim_osc_ctl_lockreg.sv
module sim_osc_ctl_lockreg;

   localparam logic [11:0] RA = 12'hF86;
   localparam logic [7:0]  KA = 8'hE7;
   localparam logic [7:0]  KB = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_opt = 1'b0;
   logic [11:0] addr = '0;
   logic [7:0]  wr_data = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_data;
   logic        int_osc_en, xtal_osc_en, wdt_osc_en, pri_fail_det_en;
   logic        wdt_fail_det_en, flash_pd_en;
   logic [1:0]  clk_src_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0] m_val;
   int         m_st;

   always #2 clk = ~clk;

   osc_ctl_lockreg u0 (
      .clk(clk), .rst_n(rst_n), .rst_opt(rst_opt), .addr(addr),
      .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
      .int_osc_en(int_osc_en), .xtal_osc_en(xtal_osc_en), .wdt_osc_en(wdt_osc_en),
      .pri_fail_det_en(pri_fail_det_en), .wdt_fail_det_en(wdt_fail_det_en),
      .flash_pd_en(flash_pd_en), .clk_src_sel(clk_src_sel)
   );

   function automatic logic [7:0] reset_value(input logic opt);
      return {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, ~opt, 2'b00};
   endfunction

   function automatic logic [7:0] exp_read(input logic re, input logic [11:0] a,
                                           input logic [7:0] v);
      return (re && a == RA) ? v : 8'h00;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] field_bus();
      return {int_osc_en, xtal_osc_en, wdt_osc_en, pri_fail_det_en,
              wdt_fail_det_en, flash_pd_en, clk_src_sel};
   endfunction

   // one bus cycle: drive at negedge, judge before the edge, update model at the edge
   task automatic bus(input logic [11:0] a, input logic [7:0] d, input logic we,
                      input logic re, input string req);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = we; rd_en = re;
      #1;
      check(req, rd_data, exp_read(re, a, m_val));
      check("R3", field_bus(), m_val);
      @(posedge clk);
      if (we && a == RA) begin
         case (m_st)
            0: m_st = (d == KA) ? 1 : 0;
            1: m_st = (d == KB) ? 2 : 0;
            default: begin m_val = d; m_st = 0; end
         endcase
      end
   endtask

   task automatic do_reset(input logic opt);
      @(negedge clk);
      rst_n = 1'b0; rst_opt = opt; wr_en = 1'b0; rd_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_val = reset_value(opt);
      m_st  = 0;
   endtask

   task automatic peek(input string req, input logic [7:0] exp);
      @(negedge clk);
      addr = RA; wr_en = 1'b0; rd_en = 1'b1;
      #1;
      check(req, rd_data, exp);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C7A));
      // R1 / R2: both reset options
      do_reset(1'b0);
      peek("R1", 8'hA4);
      check("R2", {7'd0, flash_pd_en}, 8'h01);
      do_reset(1'b1);
      peek("R1", 8'hA0);
      check("R2", {7'd0, flash_pd_en}, 8'h00);
      // R4: non-matching address and no strobe read zero
      bus(12'hF87, 8'h00, 1'b0, 1'b1, "R4");
      bus(RA, 8'h00, 1'b0, 1'b0, "R4");
      // R5: locked writes including key B alone
      bus(RA, 8'hFF, 1'b1, 1'b0, "R5");
      bus(RA, KB, 1'b1, 1'b0, "R9");
      peek("R5", 8'hA0);
      // R6: full key then store
      bus(RA, KA, 1'b1, 1'b1, "R6");
      bus(RA, KB, 1'b1, 1'b1, "R6");
      bus(RA, 8'h5A, 1'b1, 1'b0, "R6");
      peek("R6", 8'h5A);
      // R7: relocked
      bus(RA, 8'h00, 1'b1, 1'b0, "R7");
      peek("R7", 8'h5A);
      // R8: E7 E7 18 does not unlock
      bus(RA, KA, 1'b1, 1'b0, "R8");
      bus(RA, KA, 1'b1, 1'b0, "R8");
      bus(RA, KB, 1'b1, 1'b0, "R8");
      bus(RA, 8'h33, 1'b1, 1'b0, "R8");
      peek("R8", 8'h5A);
      // R10: foreign write between key bytes
      bus(RA, KA, 1'b1, 1'b0, "R10");
      bus(12'h123, 8'h77, 1'b1, 1'b1, "R10");
      bus(RA, KB, 1'b1, 1'b0, "R10");
      bus(RA, 8'h3C, 1'b1, 1'b0, "R10");
      peek("R10", 8'h3C);
      // R11: read and storing write together
      bus(RA, KA, 1'b1, 1'b0, "R11");
      bus(RA, KB, 1'b1, 1'b0, "R11");
      bus(RA, 8'hC3, 1'b1, 1'b1, "R11");
      peek("R11", 8'hC3);
      // random traffic, key bytes and own address favoured
      for (int i = 0; i < 3000; i++) begin
         logic [11:0] a;
         logic [7:0]  d;
         int          r;
         r = $urandom_range(0, 3);
         a = (r != 0) ? RA : 12'($urandom);
         r = $urandom_range(0, 3);
         d = (r == 0) ? KA : (r == 1) ? KB : 8'($urandom);
         bus(a, d, 1'($urandom), 1'($urandom), "R4");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule